// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block holds a memory device back from read and write traffic until its startup sequence is finished. After reset it idles and waits for an external indication that the supplies are up and the input clocks have settled. It then runs two timed phases back to back. The first phase gives the output drivers time to calibrate their impedance. The second phase enables the device's delay-locked loop and waits for it to lock. When both phases are done, it raises a ready flag that lets read and write operations begin.

The block does not model any analog calibration or loop behaviour. It only counts clock cycles. Both phase lengths are parameters: the defaults are 163,840 cycles for calibration and 65,536 cycles for lock, and a testbench can set short values instead.

If the clock-stable indication drops at any time, the sequencer goes back to idle and the next attempt runs both phases in full. Any access request that arrives while ready is low sets a sticky error flag, which only reset clears.

The state machine has four states, each reported on `phase_o`:
- IDLE (code 0).
- CAL (code 1).
- LOCK (code 2).
- READY (code 3).

It has five named transitions:
- START: IDLE to CAL, taken when clocks are stable.
- CAL_DONE: CAL to LOCK, taken on the last calibration cycle.
- LOCK_DONE: LOCK to READY, taken on the last lock cycle.
- LOSS: any of CAL, LOCK or READY to IDLE, taken when clocks are not stable.
- HOLD: remain in the current state otherwise.

Top module: `pwrup_seq`

## Requirements
- R1: While `clk_stable_i` is low in IDLE, the block stays in IDLE and `cal_active_o`, `dll_en_o` and `ready_o` are all low.
- R2: A high `clk_stable_i` sampled in IDLE moves the block to CAL (phase code 1). CAL lasts exactly CAL_CYCLES cycles, with `cal_active_o` high throughout.
- R3: LOCK (phase code 2) follows CAL immediately and lasts exactly LOCK_CYCLES cycles, with `dll_en_o` high.
- R4: `ready_o` (phase code 3) rises only in the cycle after the last LOCK cycle. It stays high for as long as `clk_stable_i` stays high.
- R5: `dll_en_o` rises at the start of LOCK and stays high through READY. It is low in IDLE and in CAL.
- R6: A low `clk_stable_i` sampled in CAL, LOCK or READY returns the block to IDLE at the next edge, and the counters are cleared. This takes priority over completing a phase in the same cycle. The next attempt runs full-length phases.
- R7: `access_req_i` sampled high while `ready_o` is low sets `early_err_o` at the next edge, and the flag stays set until reset. A request sampled while `ready_o` is high leaves the flag unchanged.
- R8: After reset, the block is in IDLE (phase code 0), all flags are low and `early_err_o` is 0.
- R9: The phase codes are 0 for IDLE, 1 for CAL, 2 for LOCK and 3 for READY. Exactly one of `cal_active_o`, (`dll_en_o` and not `ready_o`), `ready_o` is high outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable_i | input | 1 | Supplies up and input clocks settled |
| access_req_i | input | 1 | A read or write request from the user side |
| cal_active_o | output | 1 | Impedance calibration phase in progress |
| dll_en_o | output | 1 | Enable for the delay-locked loop |
| ready_o | output | 1 | Read and write operations permitted |
| phase_o | output | 2 | Current state code |
| early_err_o | output | 1 | Sticky flag for an access request before ready |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a loss of clock stability and the completion of a phase. The bench drops `clk_stable_i` exactly on the last CAL cycle. It expects IDLE rather than LOCK at the next edge, followed by a complete new CAL phase.

The second pair is an access request and the rise of ready. The bench asserts `access_req_i` on the last LOCK cycle, so the error flag and `ready_o` rise on the same edge. It also asserts the request in the first READY cycle of an error-free run, where the flag must stay clear.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAL   = 2'd1,
        ST_LOCK  = 2'd2,
        ST_READY = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/pwrup_cnt.sv
module pwrup_cnt #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || last_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R6: an idle counter restarts from zero
    a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
    // R2: the count never passes the phase limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);
endmodule

// File: rtl/pwrup_err.sv
module pwrup_err (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ready_i,
    output logic err_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (req_i && !ready_i)
            err_o <= 1'b1;
    end

    // R7: once set, the flag holds until reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R7: an early request always raises the flag
    a_r7_early_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ready_i) |=> err_o);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned CAL_CYCLES  = 163840,
    parameter int unsigned LOCK_CYCLES = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_stable_i,
    input  logic       access_req_i,
    output logic       cal_active_o,
    output logic       dll_en_o,
    output logic       ready_o,
    output logic [1:0] phase_o,
    output logic       early_err_o
);
    pwr_state_e state_q, state_d;
    logic cal_run, lock_run, cal_last, lock_last;

    assign cal_run  = (state_q == ST_CAL)  && clk_stable_i;
    assign lock_run = (state_q == ST_LOCK) && clk_stable_i;

    pwrup_cnt #(.LIMIT(CAL_CYCLES)) u_cal_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(cal_run), .last_o(cal_last)
    );

    pwrup_cnt #(.LIMIT(LOCK_CYCLES)) u_lock_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(lock_run), .last_o(lock_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: START, CAL_DONE, LOCK_DONE, LOSS, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (clk_stable_i) state_d = ST_CAL;
            ST_CAL:   if (!clk_stable_i) state_d = ST_IDLE;
                      else if (cal_last) state_d = ST_LOCK;
            ST_LOCK:  if (!clk_stable_i) state_d = ST_IDLE;
                      else if (lock_last) state_d = ST_READY;
            ST_READY: if (!clk_stable_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cal_active_o = 1'b0;
        dll_en_o     = 1'b0;
        ready_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CAL:   cal_active_o = 1'b1;
            ST_LOCK:  dll_en_o = 1'b1;
            ST_READY: begin
                dll_en_o = 1'b1;
                ready_o  = 1'b1;
            end
            default:  ;
        endcase
        phase_o = state_q;
    end

    pwrup_err u_err (
        .clk(clk), .rst_n(rst_n), .req_i(access_req_i),
        .ready_i(ready_o), .err_o(early_err_o)
    );

    // R1: IDLE holds without stable clocks
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && !clk_stable_i) |=> phase_o == 2'd0);
    // R4: ready rises only out of LOCK
    a_r4_ready_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(phase_o) == 2'd2);
    // R5: the loop enable stays on while clocks stay stable
    a_r5_dll_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_en_o && clk_stable_i) |=> dll_en_o);
    // R6: clock loss always returns to IDLE
    a_r6_loss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stable_i |=> phase_o == 2'd0);
    // R9: exactly one phase flag outside IDLE
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_active_o, dll_en_o && !ready_o, ready_o}));
endmodule

// File: tb/pwrup_seq_bench.sv
`timescale 1ns/1ps
module pwrup_seq_bench;
    localparam int CAL  = 20;
    localparam int LOCK = 8;

    typedef struct {
        logic [1:0] ph;
        logic       cal;
        logic       dll;
        logic       rdy;
        logic       err;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_stable_i = 1'b0;
    logic access_req_i = 1'b0;
    logic cal_active_o, dll_en_o, ready_o, early_err_o;
    logic [1:0] phase_o;

    int vectors = 0;
    int miscompares = 0;
    exp_t q[$];

    // bench model state
    int m_ph = 0;
    int m_cnt = 0;
    bit m_err = 1'b0;

    always #4 clk = ~clk;

    pwrup_seq #(.CAL_CYCLES(CAL), .LOCK_CYCLES(LOCK)) u_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .clk_stable_i(clk_stable_i),
        .access_req_i(access_req_i), .cal_active_o(cal_active_o),
        .dll_en_o(dll_en_o), .ready_o(ready_o), .phase_o(phase_o),
        .early_err_o(early_err_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "R9 phase", phase_o, e.ph);
            cmp(e.tag, "cal_active", cal_active_o, e.cal);
            cmp(e.tag, "dll_en", dll_en_o, e.dll);
            cmp(e.tag, "ready", ready_o, e.rdy);
            cmp(e.tag, "early_err", early_err_o, e.err);
        end
    end

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input bit stab, input bit req, input string tag);
        exp_t e;
        @(negedge clk);
        clk_stable_i = stab;
        access_req_i = req;
        if (req && m_ph != 3) m_err = 1'b1;
        case (m_ph)
            0: if (stab) begin m_ph = 1; m_cnt = 0; end
            1: if (!stab) m_ph = 0;
               else if (m_cnt == CAL - 1) begin m_ph = 2; m_cnt = 0; end
               else m_cnt++;
            2: if (!stab) m_ph = 0;
               else if (m_cnt == LOCK - 1) begin m_ph = 3; m_cnt = 0; end
               else m_cnt++;
            default: if (!stab) m_ph = 0;
        endcase
        e.ph  = 2'(m_ph);
        e.cal = (m_ph == 1);
        e.dll = (m_ph >= 2);
        e.rdy = (m_ph == 3);
        e.err = m_err;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input bit stab, input bit req, input string tag);
        for (int i = 0; i < n; i++) step(stab, req, tag);
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        #3;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clk_stable_i = 1'b0;
        access_req_i = 1'b0;
        m_ph = 0; m_cnt = 0; m_err = 1'b0;
        @(negedge clk);
        // R8: state right after reset
        cmp("R8", "phase", phase_o, 0);
        cmp("R8", "ready", ready_o, 0);
        cmp("R8", "dll_en", dll_en_o, 0);
        cmp("R8", "cal_active", cal_active_o, 0);
        cmp("R8", "early_err", early_err_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        run(4, 0, 0, "R1");
        run(CAL + 1, 1, 0, "R2");
        run(LOCK, 1, 0, "R3");
        run(3, 1, 1, "R7");       // request while ready: flag stays clear
        run(2, 1, 0, "R4");
        run(1, 0, 0, "R6");       // loss from READY
        run(5, 1, 0, "R6");
        run(1, 0, 0, "R6");       // loss mid CAL
        run(CAL, 1, 0, "R6");     // now on last CAL cycle
        run(1, 0, 0, "R6");       // loss beats CAL_DONE
        run(CAL + LOCK, 1, 0, "R5");
        step(1, 1, "R7");         // request on last LOCK cycle, same edge as ready
        run(3, 1, 0, "R7");
        run(2, 1, 1, "R4");
        drain();
        do_reset();
        run(2, 0, 1, "R7");       // request in IDLE
        run(2, 0, 0, "R1");
        drain();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(100000 * 8);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule